// File: doc/BRIEF.md
# DRAM refresh and power-up sequencer

This block keeps an asynchronous DRAM alive without any help from the access controller beyond a two-wire handshake. Out of reset it stays silent for a programmable pause. It then runs a burst of wake-up strobe cycles and only afterwards reports that the memory may be used. From then on a free-running interval counter adds one owed refresh every `INTERVAL` clocks, so that all rows are covered within the retention period.

Every refresh uses the column-before-row method: the column strobe goes low first, then the row strobe. The device supplies the row from its own counter, so the block drives no address and no data. The block raises `ref_req` whenever work is pending and drives the strobes only while `ref_gnt` is high. Refreshes that fall due while the grant is withheld are counted and run back to back once it returns.

If the owed count would grow past `OWE_LIMIT`, the retention deadline is treated as missed. The block then drops `ready`, raises `deadline_miss`, discards the owed count and runs the full wake-up burst again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and afterwards, until `PAUSE_CYC` clocks have passed, `ras_n` and `cas_n` are 1 and `ref_req`, `ready` and `deadline_miss` are 0.
- R2: The request rises in the clock in which the pause ends. Exactly `WAKE_CNT` strobe cycles follow, and `ready` rises in the clock in which the last of them finishes.
- R3: A strobe cycle starts only when `ref_gnt` is 1 in the idle state, and no strobe goes low while the grant is withheld. `ref_req` stays 1 while work is pending and for the whole of a cycle.
- R4: Each cycle drives `cas_n` low for `T_CSR` clocks with `ras_n` high, then drives `ras_n` low. `cas_n` stays low for as long as `ras_n` is low.
- R5: `ras_n` stays low for exactly `T_RAS` clocks. Before it falls again it is high for at least `T_RP` clocks.
- R6: Once `ready` is 1, each `INTERVAL`-clock period adds one owed refresh. Owed refreshes run back to back, with falling edges of `ras_n` spaced `T_CSR+T_RAS+T_RP+1` clocks apart while the grant is held.
- R7: When an interval elapses while `OWE_LIMIT` refreshes are already owed, `ready` falls and `deadline_miss` rises. The owed count is cleared and `WAKE_CNT` wake-up cycles are run. `ready` returns to 1 and `deadline_miss` to 0 when the last of them finishes. Up to `OWE_LIMIT` owed refreshes cause no miss.
- R8: No strobe cycle is run when no wake-up cycle and no refresh is owed, and `ref_req` is then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Refresh work pending or cycle in progress |
| ref_gnt | input | 1 | Strobes handed to this block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Pause and wake-up burst complete |
| deadline_miss | output | 1 | Owed count overran its limit; wake-up burst being repeated |

## Verification
The condition hardest to reach from the ports is a missed deadline. The controller has to hold the grant off for several whole intervals while the block keeps requesting, and must release it neither too early (only a catch-up burst follows) nor too late. The stimulus drops the grant just after a refresh completes and keeps it low across four interval boundaries. The scoreboard then expects a fresh eight-cycle burst and none of the discarded refreshes. A shorter withheld window of two intervals separately exercises the back-to-back catch-up spacing.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYC = 40000,
  parameter int INTERVAL  = 3120,
  parameter int WAKE_CNT  = 8,
  parameter int OWE_LIMIT = 8,
  parameter int T_CSR     = 1,
  parameter int T_RAS     = 10,
  parameter int T_RP      = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_req,
  input  logic ref_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic ready,
  output logic deadline_miss
);

  localparam int PW   = $clog2(PAUSE_CYC + 1);
  localparam int IW   = $clog2(INTERVAL);
  localparam int WW   = $clog2(WAKE_CNT + 1);
  localparam int OW   = $clog2(OWE_LIMIT + 1);
  localparam int TM1  = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int TMAX = (TM1 > T_CSR) ? TM1 : T_CSR;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {IDLE, SETUP, ACT, PRE} phase_t;

  phase_t        ph;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] ivl;
  logic [WW-1:0] wake_left;
  logic [OW-1:0] owed;
  logic          wake_kind;

  wire pause_done = (pause_cnt == '0);
  wire tick       = (ivl == IW'(INTERVAL - 1));
  wire done       = (ph == PRE) && (tmr == '0);
  wire wake_last  = done && wake_kind && (wake_left == WW'(1));
  wire pending    = pause_done && ((wake_left != '0) || (ready && owed != '0));
  wire owed_dec   = done && !wake_kind && (owed != '0);
  wire accrue     = pause_done && tick;
  wire miss       = accrue && !owed_dec && (owed == OW'(OWE_LIMIT));

  assign ref_req = (ph != IDLE) || pending;
  assign cas_n   = !((ph == SETUP) || (ph == ACT));
  assign ras_n   = (ph != ACT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl       <= '0;
      pause_cnt <= PW'(PAUSE_CYC);
    end else begin
      ivl <= tick ? '0 : ivl + 1'b1;
      if (!pause_done) pause_cnt <= pause_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_left     <= '0;
      owed          <= '0;
      ready         <= 1'b0;
      deadline_miss <= 1'b0;
    end else begin
      if (miss || (pause_cnt == PW'(1)))
        wake_left <= WW'(WAKE_CNT);
      else if (done && wake_kind && wake_left != '0)
        wake_left <= wake_left - 1'b1;

      if (miss) owed <= '0;
      else      owed <= owed + OW'(accrue) - OW'(owed_dec);

      if (miss) begin
        ready         <= 1'b0;
        deadline_miss <= 1'b1;
      end else if (wake_last) begin
        ready         <= 1'b1;
        deadline_miss <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= IDLE;
      tmr       <= '0;
      wake_kind <= 1'b0;
    end else begin
      case (ph)
        IDLE: if (ref_gnt && pending) begin
          ph        <= SETUP;
          tmr       <= TW'(T_CSR - 1);
          wake_kind <= (wake_left != '0);
        end
        SETUP: if (tmr == '0) begin
          ph  <= ACT;
          tmr <= TW'(T_RAS - 1);
        end else tmr <= tmr - 1'b1;
        ACT: if (tmr == '0) begin
          ph  <= PRE;
          tmr <= TW'(T_RP - 1);
        end else tmr <= tmr - 1'b1;
        PRE: if (tmr == '0) ph <= IDLE;
             else tmr <= tmr - 1'b1;
        default: ph <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int T_RAS = 10,
  parameter int T_RP  = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ref_req,
  input logic ref_gnt,
  input logic ras_n,
  input logic cas_n,
  input logic ready,
  input logic deadline_miss
);

  logic [7:0] lo_cnt;
  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 8'hff;
    end else begin
      lo_cnt <= ras_n ? '0 : lo_cnt + 1'b1;
      if (!ras_n)             hi_cnt <= '0;
      else if (hi_cnt != 8'hff) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R3
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> (ref_gnt && ref_req));

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  // R4
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt == 8'(T_RAS)));

  // R5
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 8'(T_RP)));

  // R7
  ready_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && deadline_miss));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
  .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .deadline_miss(deadline_miss)
);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;

  localparam int PAUSE_CYC = 50;
  localparam int INTERVAL  = 200;
  localparam int WAKE_CNT  = 8;
  localparam int OWE_LIMIT = 3;
  localparam int T_CSR     = 1;
  localparam int T_RAS     = 10;
  localparam int T_RP      = 6;
  localparam int SPACING   = T_CSR + T_RAS + T_RP + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b1;
  logic ref_req, ras_n, cas_n, ready, deadline_miss;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE_CYC), .INTERVAL(INTERVAL), .WAKE_CNT(WAKE_CNT),
    .OWE_LIMIT(OWE_LIMIT), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .deadline_miss(deadline_miss)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  bit pause_bad = 0;
  string exp_q[$];
  int falls[$];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push_exp(input int n, input string why);
    for (int i = 0; i < n; i++) exp_q.push_back(why);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor / scoreboard
  bit prev_ras = 1;
  int lo_run = 0, hi_run = 1000, cas_pre = 0;
  int setup_seen = 0, pre_seen = 0;
  bit cas_ok = 1, gnt_ok = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc < PAUSE_CYC && (ref_req || !ras_n || !cas_n || ready || deadline_miss))
        pause_bad = 1;
      if (ras_n) begin
        if (!prev_ras) begin
          pulses++;
          if (exp_q.size() == 0) begin
            chk(0, "R8 unexpected strobe cycle", pulses, 0);
          end else begin
            string why;
            why = exp_q.pop_front();
            chk(setup_seen == T_CSR, {"R4 column setup ", why}, setup_seen, T_CSR);
            chk(cas_ok, {"R4 column held low ", why}, cas_ok, 1);
            chk(lo_run == T_RAS, {"R5 row low width ", why}, lo_run, T_RAS);
            chk(pre_seen >= T_RP, {"R5 precharge ", why}, pre_seen, T_RP);
            chk(gnt_ok, {"R3 grant at row fall ", why}, gnt_ok, 1);
          end
          hi_run = 0;
          cas_pre = 0;
        end
        hi_run++;
        cas_pre = cas_n ? 0 : cas_pre + 1;
      end else begin
        if (prev_ras) begin
          setup_seen = cas_pre;
          pre_seen = hi_run;
          lo_run = 0;
          cas_ok = 1;
          gnt_ok = ref_gnt;
          falls.push_back(cyc);
        end
        lo_run++;
        if (cas_n) cas_ok = 0;
      end
      prev_ras = ras_n;
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 2400);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && !ref_req && !ready && !deadline_miss, "R1 reset state",
        {ras_n, cas_n, ref_req, ready, deadline_miss}, 5'b11000);
    push_exp(WAKE_CNT, "wake");
    rst_n = 1'b1;

    wait_cyc(PAUSE_CYC - 1);
    chk(!ref_req, "R1 no request before pause ends", ref_req, 0);
    wait_cyc(PAUSE_CYC);
    chk(!pause_bad, "R1 quiet during pause", pause_bad, 0);
    chk(ref_req, "R2 request at end of pause", ref_req, 1);

    wait_cyc(PAUSE_CYC + 1 + WAKE_CNT * SPACING - 2);
    chk(!ready, "R2 not ready before last wake cycle", ready, 0);
    wait_cyc(PAUSE_CYC + 1 + WAKE_CNT * SPACING - 1);
    chk(ready, "R2 ready after wake burst", ready, 1);
    chk(pulses == WAKE_CNT, "R2 wake cycle count", pulses, WAKE_CNT);
    chk(!ref_req, "R8 no request when nothing owed", ref_req, 0);

    for (int m = 1; m <= 3; m++) begin
      wait_cyc(m * INTERVAL);
      push_exp(1, "steady");
      wait_cyc(m * INTERVAL + 60);
      chk(!ref_req && exp_q.size() == 0, "R8 request drops after refresh", ref_req, 0);
    end

    wait_cyc(3 * INTERVAL + 20);
    ref_gnt = 1'b0;
    wait_cyc(5 * INTERVAL + 60);
    chk(ref_req, "R3 request held while grant withheld", ref_req, 1);
    chk(pulses == WAKE_CNT + 3, "R3 no strobes without grant", pulses, WAKE_CNT + 3);
    chk(ready && !deadline_miss, "R6 two owed is within limit", {ready, deadline_miss}, 2'b10);
    push_exp(2, "catchup");
    ref_gnt = 1'b1;
    wait_cyc(5 * INTERVAL + 70 + 3 * SPACING);
    chk(exp_q.size() == 0, "R6 owed refreshes all run", exp_q.size(), 0);
    chk(falls[falls.size()-1] - falls[falls.size()-2] == SPACING, "R6 back-to-back spacing",
        falls[falls.size()-1] - falls[falls.size()-2], SPACING);

    wait_cyc(6 * INTERVAL);
    push_exp(1, "steady");
    wait_cyc(6 * INTERVAL + 30);
    ref_gnt = 1'b0;
    wait_cyc(9 * INTERVAL + 100);
    chk(ready && !deadline_miss, "R7 owed at limit is no miss", {ready, deadline_miss}, 2'b10);
    wait_cyc(10 * INTERVAL + 10);
    chk(!ready && deadline_miss, "R7 miss flagged", {ready, deadline_miss}, 2'b01);
    chk(ref_req, "R7 wake burst requested", ref_req, 1);
    wait_cyc(10 * INTERVAL + 50);
    push_exp(WAKE_CNT, "rewake");
    ref_gnt = 1'b1;
    wait_cyc(10 * INTERVAL + 51 + WAKE_CNT * SPACING - 2);
    chk(!ready && deadline_miss, "R7 still recovering", {ready, deadline_miss}, 2'b01);
    wait_cyc(10 * INTERVAL + 51 + WAKE_CNT * SPACING - 1);
    chk(ready && !deadline_miss, "R7 recovered after rewake", {ready, deadline_miss}, 2'b10);
    chk(exp_q.size() == 0 && !ref_req, "R7 owed count discarded", ref_req, 0);

    wait_cyc(11 * INTERVAL);
    push_exp(1, "steady");
    wait_cyc(11 * INTERVAL + 100);
    chk(exp_q.size() == 0, "R6 refresh resumes after recovery", exp_q.size(), 0);
    chk(pulses == 2 * WAKE_CNT + 7, "R8 total strobe cycles", pulses, 2 * WAKE_CNT + 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule